// File: doc/BRIEF.md
# Debug breakpoint match unit

This block watches the processor's instruction fetch stream and its data access stream and raises a debug exception request when an access lands on a programmed breakpoint. Two instruction breakpoint registers compare word-aligned fetch addresses. Two data breakpoint registers compare full byte addresses, and a control register chooses which kind of access each one reacts to. A debug agent programs all five registers through a simple write-only port.

The control register can switch the second data register into a different role. In that setting it stops matching on its own and becomes a don't-care mask for the first data comparator, so one breakpoint can cover an aligned address range. Two event inputs, an external debug request and a trace-buffer-full flag, share the same output path. When several events arrive in one cycle, a fixed priority picks the cause code. The hit and the cause code are registered and appear one clock after the access or event that produced them.

Top module: `dbg_bkpt_unit`

## Requirements
- R1: After a synchronous active-low reset, `hit` is 0, `cause` is 0 and every breakpoint register holds zero with its comparison disabled, so no valid access produces a hit.
- R2: An instruction breakpoint register whose bit 0 is 1 gives `hit`=1 and `cause`=2 one cycle after a valid fetch whose address bits [31:2] equal the register's bits [31:2]. Fetch address bits [1:0] do not take part in the comparison.
- R3: An instruction breakpoint register whose bit 0 is 0 never produces a hit.
- R4: Each data comparator has a 2-bit mode field in the control register: bits [1:0] for data register 0 and bits [3:2] for data register 1. The codes are 00 off, 01 stores only (`dacc_write`=1), 10 any access, and 11 loads only (`dacc_write`=0). A qualifying valid access with an exactly equal 32-bit address gives `hit`=1 and `cause`=3 one cycle later.
- R5: When control bit 8 is 0, data register 1 is an independent comparator under its own mode field.
- R6: When control bit 8 is 1, comparator 0 ignores every address bit that is 1 in data register 1. Data register 1 then produces no hit of its own, whatever its mode field holds.
- R7: The cause codes are 1 for an external request, 2 for an instruction breakpoint, 3 for a data breakpoint and 4 for trace buffer full. When several occur together the code follows that priority, external first and trace-full last, and no other value appears.
- R8: `ext_dbg_req` or `trace_full` held high in a cycle gives `hit`=1 the next cycle, and `hit` is 1 exactly when `cause` is non-zero.
- R9: With `fetch_valid` and `dacc_valid` low and no event input, the next cycle shows `hit`=0. A hit therefore lasts one cycle per qualifying cycle.
- R10: `cfg_sel` picks the register to write: 0 and 1 are the instruction registers, 2 and 3 the data registers, 4 the control register. Writes with `cfg_sel` of 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select for the write |
| cfg_wdata | input | 32 | Write data |
| fetch_valid | input | 1 | Fetch address is valid this cycle |
| fetch_addr | input | 32 | Instruction fetch address |
| dacc_valid | input | 1 | Data access is valid this cycle |
| dacc_addr | input | 32 | Data access byte address |
| dacc_write | input | 1 | 1 for a store, 0 for a load |
| ext_dbg_req | input | 1 | External debug request |
| trace_full | input | 1 | Trace buffer has filled |
| hit | output | 1 | Breakpoint hit, one cycle after the cause |
| cause | output | 3 | Cause code of the reported hit |

## Verification
The assertions check on every cycle that the hit flag and the cause code agree, that the cause code stays within its legal set, that an external request always wins the next cycle, that trace-full alone reports code 4, that an idle cycle is followed by no hit, and that reset quiets the output. The address comparisons cannot be shown this way: word alignment, the store, load and any-access qualifiers, the mask mode and its suppression of the second comparator, and writes to unused selects are all shown only by the bench's programmed scenarios.

// File: rtl/dbg_bkpt_pkg.sv
// Package: shared types for the breakpoint match unit.
// Holds the cause codes, the data-access mode encoding and the
// bit positions of the data-breakpoint control word.
package dbg_bkpt_pkg;

    typedef enum logic [2:0] {
        CAUSE_NONE  = 3'd0,
        CAUSE_EXT   = 3'd1,
        CAUSE_IBKPT = 3'd2,
        CAUSE_DBKPT = 3'd3,
        CAUSE_TRACE = 3'd4
    } dbg_cause_e;

    typedef enum logic [1:0] {
        DMODE_OFF   = 2'b00,
        DMODE_STORE = 2'b01,
        DMODE_ANY   = 2'b10,
        DMODE_LOAD  = 2'b11
    } dmode_e;

    localparam int CTL_D0_LSB   = 0;
    localparam int CTL_D1_LSB   = 2;
    localparam int CTL_MASK_BIT = 8;

    typedef struct packed {
        dmode_e mode0;
        dmode_e mode1;
        logic   mask_en;
    } dctl_t;

    // Does a data access of the given direction qualify under a mode?
    function automatic logic dmode_allows(dmode_e m, logic is_write);
        logic ok;
        case (m)
            DMODE_STORE: ok = is_write;
            DMODE_ANY:   ok = 1'b1;
            DMODE_LOAD:  ok = !is_write;
            default:     ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/dbg_bkpt_regs.sv
// Module: breakpoint register bank.
// Holds NUM_IBP instruction breakpoint registers, two data breakpoint
// registers and the data control word. Write-only; a write with a select
// outside the map is dropped. Assumes one write per cycle.
module dbg_bkpt_regs
    import dbg_bkpt_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int NUM_IBP = 2,
    parameter int SEL_W   = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [SEL_W-1:0]          cfg_sel,
    input  logic [ADDR_W-1:0]         cfg_wdata,
    output logic [NUM_IBP*ADDR_W-1:0] ibr_flat,
    output logic [ADDR_W-1:0]         dbr0,
    output logic [ADDR_W-1:0]         dbr1,
    output dctl_t                     dctl
);

    localparam int SEL_DBR0 = NUM_IBP;
    localparam int SEL_DBR1 = NUM_IBP + 1;
    localparam int SEL_CTL  = NUM_IBP + 2;

    for (genvar g = 0; g < NUM_IBP; g++) begin : g_ibr
        logic [ADDR_W-1:0] ibr_q;

        // Load instruction breakpoint register g on its select.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ibr_q <= '0;
            end else if (cfg_we && cfg_sel == SEL_W'(g)) begin
                ibr_q <= cfg_wdata;
            end
        end

        assign ibr_flat[g*ADDR_W +: ADDR_W] = ibr_q;
    end

    // Load the two data breakpoint address registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dbr0 <= '0;
            dbr1 <= '0;
        end else if (cfg_we) begin
            if (cfg_sel == SEL_W'(SEL_DBR0)) dbr0 <= cfg_wdata;
            if (cfg_sel == SEL_W'(SEL_DBR1)) dbr1 <= cfg_wdata;
        end
    end

    // Load the data control word from its fields in the write data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dctl <= '{mode0: DMODE_OFF, mode1: DMODE_OFF, mask_en: 1'b0};
        end else if (cfg_we && cfg_sel == SEL_W'(SEL_CTL)) begin
            dctl.mode0   <= dmode_e'(cfg_wdata[CTL_D0_LSB +: 2]);
            dctl.mode1   <= dmode_e'(cfg_wdata[CTL_D1_LSB +: 2]);
            dctl.mask_en <= cfg_wdata[CTL_MASK_BIT];
        end
    end

endmodule

// File: rtl/dbg_ibp_match.sv
// Module: one instruction-address comparator.
// Matches a valid fetch against an enabled breakpoint register on
// address bits above ALIGN_LSB; bit 0 of the register is the enable.
// Assumes ALIGN_LSB >= 2 so the enable bit sits below the compared field.
module dbg_ibp_match #(
    parameter int ADDR_W    = 32,
    parameter int ALIGN_LSB = 2
) (
    input  logic [ADDR_W-1:0] bp_reg,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              match
);

    logic unused_low_bits;

    // Compare the aligned part of the fetch address with the register.
    always_comb begin
        match = fetch_valid && bp_reg[0]
                && (bp_reg[ADDR_W-1:ALIGN_LSB] == fetch_addr[ADDR_W-1:ALIGN_LSB]);
    end

    assign unused_low_bits = ^{bp_reg[ALIGN_LSB-1:1], fetch_addr[ALIGN_LSB-1:0]};

endmodule

// File: rtl/dbg_dbp_match.sv
// Module: data-address comparator pair.
// Comparator 0 checks dbr0 under an optional don't-care mask. Comparator 1
// checks dbr1 exactly, unless mask mode turns dbr1 into that mask.
// Each comparator is qualified by its access mode and the access direction.
module dbg_dbp_match
    import dbg_bkpt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] dbr0,
    input  logic [ADDR_W-1:0] dbr1,
    input  dctl_t             dctl,
    input  logic              dacc_valid,
    input  logic [ADDR_W-1:0] dacc_addr,
    input  logic              dacc_write,
    output logic              match
);

    logic [ADDR_W-1:0] care_mask;
    logic              cmp0_hit;
    logic              cmp1_hit;

    // Bits set in dbr1 become don't-care for comparator 0 in mask mode.
    always_comb begin
        care_mask = dctl.mask_en ? ~dbr1 : '1;
    end

    // Comparator 0: masked address equality under mode field 0.
    always_comb begin
        cmp0_hit = dacc_valid && dmode_allows(dctl.mode0, dacc_write)
                   && (((dacc_addr ^ dbr0) & care_mask) == '0);
    end

    // Comparator 1: exact equality, silent while serving as the mask.
    always_comb begin
        cmp1_hit = dacc_valid && !dctl.mask_en
                   && dmode_allows(dctl.mode1, dacc_write)
                   && (dacc_addr == dbr1);
    end

    assign match = cmp0_hit || cmp1_hit;

endmodule

// File: rtl/dbg_cause_sel.sv
// Module: cause priority and output register.
// Picks one cause by fixed priority (external, instruction, data, trace
// full) and registers it with a separately formed hit flag.
module dbg_cause_sel
    import dbg_bkpt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ext_req,
    input  logic       ib_hit,
    input  logic       db_hit,
    input  logic       trace_full,
    output logic       hit_q,
    output dbg_cause_e cause_q
);

    dbg_cause_e cause_d;

    // Resolve simultaneous causes by fixed priority.
    always_comb begin
        if (ext_req)         cause_d = CAUSE_EXT;
        else if (ib_hit)     cause_d = CAUSE_IBKPT;
        else if (db_hit)     cause_d = CAUSE_DBKPT;
        else if (trace_full) cause_d = CAUSE_TRACE;
        else                 cause_d = CAUSE_NONE;
    end

    // Register hit and cause for presentation one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q   <= 1'b0;
            cause_q <= CAUSE_NONE;
        end else begin
            hit_q   <= ext_req || ib_hit || db_hit || trace_full;
            cause_q <= cause_d;
        end
    end

endmodule

// File: rtl/dbg_bkpt_unit.sv
// Module: debug breakpoint match unit (top).
// Ties the register bank to NUM_IBP instruction comparators, the data
// comparator pair and the cause selector. Results are registered once.
// Assumes fetch and data addresses are sampled in the cycle valid is high.
module dbg_bkpt_unit
    import dbg_bkpt_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int NUM_IBP   = 2,
    parameter int SEL_W     = 3,
    parameter int ALIGN_LSB = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              dacc_valid,
    input  logic [ADDR_W-1:0] dacc_addr,
    input  logic              dacc_write,
    input  logic              ext_dbg_req,
    input  logic              trace_full,
    output logic              hit,
    output logic [2:0]        cause
);

    logic [NUM_IBP*ADDR_W-1:0] ibr_flat;
    logic [ADDR_W-1:0]         dbr0;
    logic [ADDR_W-1:0]         dbr1;
    dctl_t                     dctl;
    logic [NUM_IBP-1:0]        ib_match;
    logic                      db_match;
    dbg_cause_e                cause_q;

    dbg_bkpt_regs #(
        .ADDR_W  (ADDR_W),
        .NUM_IBP (NUM_IBP),
        .SEL_W   (SEL_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .ibr_flat  (ibr_flat),
        .dbr0      (dbr0),
        .dbr1      (dbr1),
        .dctl      (dctl)
    );

    for (genvar g = 0; g < NUM_IBP; g++) begin : g_ibp
        dbg_ibp_match #(
            .ADDR_W    (ADDR_W),
            .ALIGN_LSB (ALIGN_LSB)
        ) u_ibp (
            .bp_reg      (ibr_flat[g*ADDR_W +: ADDR_W]),
            .fetch_valid (fetch_valid),
            .fetch_addr  (fetch_addr),
            .match       (ib_match[g])
        );
    end

    dbg_dbp_match #(
        .ADDR_W (ADDR_W)
    ) u_dbp (
        .dbr0       (dbr0),
        .dbr1       (dbr1),
        .dctl       (dctl),
        .dacc_valid (dacc_valid),
        .dacc_addr  (dacc_addr),
        .dacc_write (dacc_write),
        .match      (db_match)
    );

    dbg_cause_sel u_cause (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_req    (ext_dbg_req),
        .ib_hit     (|ib_match),
        .db_hit     (db_match),
        .trace_full (trace_full),
        .hit_q      (hit),
        .cause_q    (cause_q)
    );

    assign cause = cause_q;

endmodule

// File: rtl/dbg_bkpt_unit_chk.sv
// Module: cycle-level checker for the breakpoint match unit, bound to the top.
module dbg_bkpt_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fetch_valid,
    input logic       dacc_valid,
    input logic       ext_dbg_req,
    input logic       trace_full,
    input logic       hit,
    input logic [2:0] cause
);

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (!hit && cause == 3'd0)); // R1

    AST_HIT_MATCHES_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        hit == (cause != 3'd0)); // R8

    AST_CAUSE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        cause <= 3'd4); // R7

    AST_EXT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ext_dbg_req |=> (hit && cause == 3'd1)); // R7

    AST_TRACE_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        (trace_full && !ext_dbg_req && !fetch_valid && !dacc_valid) |=> (hit && cause == 3'd4)); // R8

    AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_valid && !dacc_valid && !ext_dbg_req && !trace_full) |=> !hit); // R9

endmodule

bind dbg_bkpt_unit dbg_bkpt_unit_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_valid (fetch_valid),
    .dacc_valid  (dacc_valid),
    .ext_dbg_req (ext_dbg_req),
    .trace_full  (trace_full),
    .hit         (hit),
    .cause       (cause)
);

// File: tb/dbg_bkpt_unit_test.sv
module dbg_bkpt_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        dacc_valid = 1'b0;
    logic [31:0] dacc_addr = '0;
    logic        dacc_write = 1'b0;
    logic        ext_dbg_req = 1'b0;
    logic        trace_full = 1'b0;
    logic        hit;
    logic [2:0]  cause;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    bit         exp_hit_q[$];
    logic [2:0] exp_cause_q[$];
    string      tag_q[$];

    dbg_bkpt_unit uut (
        .clk (clk), .rst_n (rst_n),
        .cfg_we (cfg_we), .cfg_sel (cfg_sel), .cfg_wdata (cfg_wdata),
        .fetch_valid (fetch_valid), .fetch_addr (fetch_addr),
        .dacc_valid (dacc_valid), .dacc_addr (dacc_addr), .dacc_write (dacc_write),
        .ext_dbg_req (ext_dbg_req), .trace_full (trace_full),
        .hit (hit), .cause (cause)
    );

    always #5 clk = ~clk;

    task automatic cfg_write(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        fetch_valid = 1'b0; dacc_valid = 1'b0; ext_dbg_req = 1'b0; trace_full = 1'b0;
    endtask

    // Drive one stimulus cycle and queue the result expected after the next edge.
    task automatic vec(input logic fv, input logic [31:0] fa,
                       input logic dv, input logic [31:0] da, input logic dw,
                       input logic ext, input logic tr,
                       input bit eh, input logic [2:0] ec, input string tag);
        @(negedge clk);
        cfg_we = 1'b0;
        fetch_valid = fv; fetch_addr = fa;
        dacc_valid = dv; dacc_addr = da; dacc_write = dw;
        ext_dbg_req = ext; trace_full = tr;
        exp_hit_q.push_back(eh);
        exp_cause_q.push_back(ec);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare each registered result against the queued expectation.
    always @(posedge clk) begin
        #2;
        if (exp_hit_q.size() > 0) begin
            bit         eh;
            logic [2:0] ec;
            string      tg;
            eh = exp_hit_q.pop_front();
            ec = exp_cause_q.pop_front();
            tg = tag_q.pop_front();
            n_vec++;
            if (hit !== eh || cause !== ec) begin
                n_bad++;
                $display("FAIL %s: hit=%0b cause=%0d expected hit=%0b cause=%0d",
                         tg, hit, cause, eh, ec);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        n_vec++;
        if (hit !== 1'b0 || cause !== 3'd0) begin
            n_bad++;
            $display("FAIL R1 reset: hit=%0b cause=%0d expected hit=0 cause=0", hit, cause);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R1: all comparators off after reset, even at address zero.
        vec(1, 32'h0, 1, 32'h0, 1, 0, 0, 0, 3'd0, "R1 fetch/data at 0");
        vec(1, 32'h0, 1, 32'h0, 0, 0, 0, 0, 3'd0, "R1 load at 0");

        // R2 / R9: instruction breakpoint 0.
        cfg_write(3'd0, 32'h1000_0001);
        vec(1, 32'h1000_0002, 0, 0, 0, 0, 0, 1, 3'd2, "R2 low bits ignored");
        vec(1, 32'h1000_0004, 0, 0, 0, 0, 0, 0, 3'd0, "R2 next word no hit");
        vec(0, 32'h1000_0000, 0, 0, 0, 0, 0, 0, 3'd0, "R9 invalid fetch");
        vec(1, 32'h1000_0000, 0, 0, 0, 0, 0, 1, 3'd2, "R2 exact word");
        vec(0, 32'h0, 0, 0, 0, 0, 0, 0, 3'd0, "R9 hit lasts one cycle");

        // R3: disabled register 1, then enabled.
        cfg_write(3'd1, 32'h2000_0010);
        vec(1, 32'h2000_0010, 0, 0, 0, 0, 0, 0, 3'd0, "R3 disabled ibr1");
        cfg_write(3'd1, 32'h2000_0011);
        vec(1, 32'h2000_0013, 0, 0, 0, 0, 0, 1, 3'd2, "R2 ibr1 enabled");

        // R4 / R5: D0 store only, D1 load only (control 0xD).
        cfg_write(3'd2, 32'h3000_0000);
        cfg_write(3'd3, 32'h4000_0008);
        cfg_write(3'd4, 32'h0000_000D);
        vec(0, 0, 1, 32'h3000_0000, 1, 0, 0, 1, 3'd3, "R4 store on store-only");
        vec(0, 0, 1, 32'h3000_0000, 0, 0, 0, 0, 3'd0, "R4 load on store-only");
        vec(0, 0, 1, 32'h3000_0001, 1, 0, 0, 0, 3'd0, "R4 byte address differs");
        vec(0, 0, 1, 32'h4000_0008, 0, 0, 0, 1, 3'd3, "R5 load on load-only");
        vec(0, 0, 1, 32'h4000_0008, 1, 0, 0, 0, 3'd0, "R5 store on load-only");
        vec(0, 0, 0, 32'h3000_0000, 1, 0, 0, 0, 3'd0, "R9 invalid data access");

        // R4: D0 any access, D1 off.
        cfg_write(3'd4, 32'h0000_0002);
        vec(0, 0, 1, 32'h3000_0000, 0, 0, 0, 1, 3'd3, "R4 any mode load");
        vec(0, 0, 1, 32'h3000_0000, 1, 0, 0, 1, 3'd3, "R4 any mode store");
        vec(0, 0, 1, 32'h4000_0008, 0, 0, 0, 0, 3'd0, "R4 D1 off");

        // R7 / R8: priority between simultaneous causes.
        vec(1, 32'h1000_0000, 1, 32'h3000_0000, 0, 1, 1, 1, 3'd1, "R7 all four");
        vec(1, 32'h1000_0000, 1, 32'h3000_0000, 0, 0, 1, 1, 3'd2, "R7 ibkpt over data");
        vec(0, 32'h1000_0000, 1, 32'h3000_0000, 0, 0, 1, 1, 3'd3, "R7 data over trace");
        vec(0, 0, 0, 0, 0, 0, 1, 1, 3'd4, "R8 trace full alone");
        vec(0, 0, 0, 0, 0, 1, 0, 1, 3'd1, "R8 external alone");
        vec(1, 32'h1000_0000, 0, 0, 0, 0, 1, 1, 3'd2, "R7 ibkpt over trace");

        // R10: writes to unmapped selects change nothing.
        cfg_write(3'd5, 32'hFFFF_FFFF);
        cfg_write(3'd7, 32'hFFFF_FFFF);
        cfg_write(3'd6, 32'h0000_0000);
        vec(0, 0, 1, 32'h3000_0000, 1, 0, 0, 1, 3'd3, "R10 control kept");
        vec(1, 32'h1000_0000, 0, 0, 0, 0, 0, 1, 3'd2, "R10 ibr0 kept");
        vec(1, 32'h2000_0010, 0, 0, 0, 0, 0, 1, 3'd2, "R10 ibr1 kept");
        vec(0, 0, 1, 32'h4000_0008, 0, 0, 0, 0, 3'd0, "R10 D1 still off");

        // R4: both data comparators off.
        cfg_write(3'd4, 32'h0000_0000);
        vec(0, 0, 1, 32'h3000_0000, 1, 0, 0, 0, 3'd0, "R4 mode off");

        // R6: mask mode, dbr1 = 0xFF as don't-care bits.
        cfg_write(3'd3, 32'h0000_00FF);
        cfg_write(3'd4, 32'h0000_010A);
        vec(0, 0, 1, 32'h3000_00AB, 0, 0, 0, 1, 3'd3, "R6 masked load");
        vec(0, 0, 1, 32'h3000_0055, 1, 0, 0, 1, 3'd3, "R6 masked store");
        vec(0, 0, 1, 32'h3000_0100, 0, 0, 0, 0, 3'd0, "R6 unmasked bit differs");
        vec(0, 0, 1, 32'h0000_00FF, 0, 0, 0, 0, 3'd0, "R6 D1 silent as mask");

        // R5: mask mode off again, D1 matches 0xFF on its own.
        cfg_write(3'd4, 32'h0000_000A);
        vec(0, 0, 1, 32'h0000_00FF, 0, 0, 0, 1, 3'd3, "R5 D1 independent");
        vec(0, 0, 1, 32'h3000_00AB, 0, 0, 0, 0, 3'd0, "R5 D0 exact again");
        vec(0, 0, 0, 0, 0, 0, 0, 0, 3'd0, "R9 idle");

        repeat (3) @(posedge clk);
        #3;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(20000 * 10);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule